// File: doc/BRIEF.md
# I2C Byte Framer

This block frames a single transfer on the I2C data line. A separate front end supplies one-cycle strobes for rising and falling SCL edges, plus start and stop detection and the synchronized SDA level. Using these, the framer shifts a programmable number of bits out of or into the line, most significant bit first. It then runs the acknowledge slot, either driving the acknowledge or sampling it. The block only drives an open-drain pull-down enable. SCL is generated elsewhere.

In the slave role, the first unit after a start is checked against a 7-bit own address and against the general-call address. A node that is not addressed stays silent until the next start. A free-data setting turns address recognition off, so every bit after a start is treated as data.

Received data leaves the block on `rx_byte`, qualified by the `byte_done` valid pulse. There is no ready, because the bus cannot be held from this side. A consumer must take the byte before the next transfer's last bit overwrites it. Transmit data enters on `tx_data` and is captured in the cycle `tx_take` pulses: at a start, and when a transfer finishes. There is no back-pressure on this side either, so the next byte must already be present at that moment.

Top module: `i2c_byte_framer`

## Requirements
- R1: `bit_cnt_cfg` sets the width of the next transfer, latched when the previous transfer finishes. Codes 1 to 7 mean that many bits and code 0 means 8. A received N-bit unit appears right-aligned in `rx_byte[N-1:0]` with the upper bits zero. A transmitted N-bit unit sends `tx_data[7:8-N]`.
- R2: The first unit after `start_det` is always 8 bits wide, whatever `bit_cnt_cfg` holds.
- R3: Bits travel most significant first. `sda_pull` changes only on an `scl_fall` strobe, and `sda_in` is sampled only on an `scl_rise` strobe. A transmitted 0 is sent as `sda_pull`=1.
- R4: A transmitter keeps `sda_pull`=0 during the acknowledge slot. It sets `rx_ack`=1 if `sda_in` is low at that slot's rising strobe, and 0 otherwise.
- R5: A receiver drives `sda_pull`=1 during the acknowledge slot when `ack_en`=1, and leaves SDA released when `ack_en`=0. The exceptions are covered by R7 to R9.
- R6: A slave always counts an acknowledge slot after every unit. A master (`is_master`=1) runs an acknowledge slot only when `ack_en`=1.
- R7: In the slave role with `free_data`=0, a first unit whose upper 7 bits equal `own_addr` sets `addr_match`=1 and is acknowledged when `ack_en`=1. `addr_match` is cleared by the next start.
- R8: A non-matching, non-general-call address is not acknowledged. `sda_pull` then stays 0 for every later unit until the next start.
- R9: A first unit of 8'h00 in the slave role is a general call. It sets `gc_flag` until `stop_det` and is acknowledged when `ack_en`=1. The unit that follows it is acknowledged according to `gc_ack` instead of `ack_en`.
- R10: With `free_data`=1, the first unit after a start is plain data. It is acknowledged according to `ack_en` and leaves `addr_match` and `gc_flag` at 0.
- R11: `byte_done` pulses for one cycle after each finished unit. In a unit with an acknowledge slot it follows the slot's rising strobe, and in a unit without one it follows the last bit's rising strobe. `rx_byte` is updated at the last data bit, and `tx_take` pulses on every start.
- R12: After reset, `sda_pull`, `byte_done`, `rx_byte`, `rx_ack`, `addr_match` and `gc_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| start_det | input | 1 | Start or repeated-start detected |
| stop_det | input | 1 | Stop detected |
| sda_in | input | 1 | Synchronized SDA line level |
| bit_cnt_cfg | input | 3 | Width code for the next unit (0 means 8) |
| ack_en | input | 1 | Acknowledge mode |
| free_data | input | 1 | 1 disables address recognition |
| own_addr | input | 7 | Own slave address |
| is_master | input | 1 | 1 selects the master role |
| dir_tx | input | 1 | 1 means this node transmits the data units |
| gc_ack | input | 1 | Acknowledge decision for the unit after a general call |
| tx_data | input | 8 | Next unit to transmit |
| tx_take | output | 1 | Pulse: `tx_data` captured |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| rx_byte | output | 8 | Last received unit, right-aligned |
| byte_done | output | 1 | Valid pulse for `rx_byte` / end of unit |
| rx_ack | output | 1 | Acknowledge seen in the last slot (1 = low) |
| addr_match | output | 1 | Own address recognized |
| gc_flag | output | 1 | General call seen since the last stop |

## Verification
Several properties are checked on every cycle: no pull-down while idle or muted after a foreign address; the counters reloaded to an 8-bit unit after a start; the general-call flag rising only on an address evaluation and dropping after a stop; and the receive shift state cleared on every load. Other behaviour only shows up in the bench's scenarios. This covers the bit order and right alignment of narrow units, the acknowledge-slot decision for each role and each case (address, general call, free data), whether a slot exists at all, and the exact strobe after which `byte_done` appears.

// File: rtl/i2c_bf_pkg.sv
package i2c_bf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BITS = 2'd1,
    PH_ACK  = 2'd2,
    PH_MUTE = 2'd3
  } phase_t;

  function automatic logic [CNT_W-1:0] width_of(input logic [CNT_W-2:0] code);
    width_of = (code == '0) ? CNT_W'(BYTE_W) : {1'b0, code};
  endfunction
endpackage

// File: rtl/i2c_bf_shifter.sv
module i2c_bf_shifter
  import i2c_bf_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift_out,
  input  logic         sample,
  input  logic         rx_we,
  input  logic         sda_in,
  input  logic [W-1:0] tx_data,
  output logic         tx_msb,
  output logic [W-1:0] rx_next,
  output logic [W-1:0] rx_byte
);
  logic [W-1:0] tx_q, rx_q;

  assign tx_msb  = tx_q[W-1];
  assign rx_next = {rx_q[W-2:0], sda_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      rx_byte <= '0;
    end else begin
      if (rx_we) rx_byte <= rx_next;
      if (load) begin
        tx_q <= tx_data;
        rx_q <= '0;
      end else begin
        if (shift_out) tx_q <= {tx_q[W-2:0], 1'b0};
        if (sample)    rx_q <= rx_next;
      end
    end
  end

  // R1: a fresh unit starts with an empty receive shifter
  a_r1_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rx_q == '0));
endmodule

// File: rtl/i2c_bf_addr.sv
module i2c_bf_addr
  import i2c_bf_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          eval,
  input  logic [W-1:0]  rx_word,
  input  logic [AW-1:0] own_addr,
  output logic          hit,
  output logic          gc,
  output logic          addr_match,
  output logic          gc_flag
);
  assign hit = (rx_word[W-1:W-AW] == own_addr);
  assign gc  = (rx_word == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_match <= 1'b0;
      gc_flag    <= 1'b0;
    end else begin
      if (start_det)  addr_match <= 1'b0;
      else if (eval)  addr_match <= hit;
      if (stop_det)   gc_flag <= 1'b0;
      else if (eval && gc) gc_flag <= 1'b1;
    end
  end

  // R9: general-call flag is raised only by an address evaluation
  a_r9_gc_from_eval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_flag) |-> $past(eval));
  // R9: a stop always clears the general-call flag
  a_r9_gc_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !gc_flag);
endmodule

// File: rtl/i2c_bf_seq.sv
module i2c_bf_seq
  import i2c_bf_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_in,
  input  logic [CW-2:0] bit_cnt_cfg,
  input  logic          ack_en,
  input  logic          free_data,
  input  logic          is_master,
  input  logic          dir_tx,
  input  logic          gc_ack,
  input  logic          tx_msb,
  input  logic          addr_hit,
  input  logic          addr_gc,
  output logic          load,
  output logic          shift_out,
  output logic          sample,
  output logic          rx_we,
  output logic          eval,
  output logic          sda_pull,
  output logic          byte_done,
  output logic          rx_ack
);
  phase_t        phase;
  logic          first_q, ack_drive_q, mute_q, gc_pend_q;
  logic [CW-1:0] width_q, cnt_q;

  logic quiet, xmit, addr_slave, last, ack_clk, end_bits, ack_rise, finish, ack_want;

  assign quiet      = !start_det && !stop_det;
  assign xmit       = first_q ? is_master : dir_tx;
  assign addr_slave = first_q && !is_master && !free_data;
  assign last       = (cnt_q + 1'b1) == width_q;
  assign ack_clk    = is_master ? ack_en : 1'b1;
  assign sample     = quiet && (phase == PH_BITS) && scl_rise;
  assign shift_out  = quiet && (phase == PH_BITS) && scl_fall;
  assign end_bits   = sample && last;
  assign ack_rise   = quiet && (phase == PH_ACK) && scl_rise;
  assign finish     = ack_rise || (end_bits && !ack_clk);
  assign load       = start_det || finish;
  assign rx_we      = end_bits;
  assign eval       = end_bits && addr_slave;

  always_comb begin
    if (xmit)            ack_want = 1'b0;
    else if (addr_slave) ack_want = (addr_hit || addr_gc) && ack_en;
    else if (gc_pend_q)  ack_want = gc_ack;
    else                 ack_want = ack_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      first_q     <= 1'b0;
      ack_drive_q <= 1'b0;
      mute_q      <= 1'b0;
      gc_pend_q   <= 1'b0;
      width_q     <= CW'(BYTE_W);
      cnt_q       <= '0;
      sda_pull    <= 1'b0;
      byte_done   <= 1'b0;
      rx_ack      <= 1'b0;
    end else begin
      byte_done <= finish;
      if (start_det) begin
        phase     <= PH_BITS;
        first_q   <= 1'b1;
        width_q   <= CW'(BYTE_W);
        cnt_q     <= '0;
        sda_pull  <= 1'b0;
        mute_q    <= 1'b0;
        gc_pend_q <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        first_q  <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (phase)
          PH_BITS: begin
            if (scl_fall) sda_pull <= xmit && !tx_msb;
            if (sample)   cnt_q <= cnt_q + 1'b1;
            if (end_bits) begin
              ack_drive_q <= ack_want;
              mute_q      <= addr_slave && !(addr_hit || addr_gc);
              gc_pend_q   <= addr_slave && addr_gc;
              if (ack_clk) phase <= PH_ACK;
            end
          end
          PH_ACK: begin
            if (scl_fall) sda_pull <= ack_drive_q;
            if (scl_rise) begin
              rx_ack <= !sda_in;
              phase  <= mute_q ? PH_MUTE : PH_BITS;
            end
          end
          PH_MUTE: if (scl_fall) sda_pull <= 1'b0;
          default: ;
        endcase
        if (finish) begin
          first_q <= 1'b0;
          cnt_q   <= '0;
          width_q <= width_of(bit_cnt_cfg);
        end
      end
    end
  end

  // R12: nothing is driven while no transfer is open
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull);
  // R8: an unaddressed slave keeps the line released
  a_r8_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MUTE) |-> !sda_pull);
  // R2: a start opens an 8-bit unit from bit zero
  a_r2_start_width: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (width_q == CW'(BYTE_W)) && (cnt_q == '0) && (phase == PH_BITS));
  // R3: the line drive only moves on a falling strobe or a start/stop
  a_r3_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall && !start_det && !stop_det |=> $stable(sda_pull));
endmodule

// File: rtl/i2c_byte_framer.sv
module i2c_byte_framer
  import i2c_bf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 sda_in,
  input  logic [CNT_W-2:0]     bit_cnt_cfg,
  input  logic                 ack_en,
  input  logic                 free_data,
  input  logic [ADDR_W-1:0]    own_addr,
  input  logic                 is_master,
  input  logic                 dir_tx,
  input  logic                 gc_ack,
  input  logic [BYTE_W-1:0]    tx_data,
  output logic                 tx_take,
  output logic                 sda_pull,
  output logic [BYTE_W-1:0]    rx_byte,
  output logic                 byte_done,
  output logic                 rx_ack,
  output logic                 addr_match,
  output logic                 gc_flag
);
  logic load, shift_out, sample, rx_we, eval, tx_msb, hit, gc;
  logic [BYTE_W-1:0] rx_next;

  assign tx_take = load;

  i2c_bf_seq #(.CW(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_in),
    .bit_cnt_cfg(bit_cnt_cfg), .ack_en(ack_en), .free_data(free_data),
    .is_master(is_master), .dir_tx(dir_tx), .gc_ack(gc_ack),
    .tx_msb(tx_msb), .addr_hit(hit), .addr_gc(gc),
    .load(load), .shift_out(shift_out), .sample(sample), .rx_we(rx_we),
    .eval(eval), .sda_pull(sda_pull), .byte_done(byte_done), .rx_ack(rx_ack)
  );

  i2c_bf_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_out(shift_out),
    .sample(sample), .rx_we(rx_we), .sda_in(sda_in), .tx_data(tx_data),
    .tx_msb(tx_msb), .rx_next(rx_next), .rx_byte(rx_byte)
  );

  i2c_bf_addr #(.W(BYTE_W), .AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .eval(eval), .rx_word(rx_next), .own_addr(own_addr),
    .hit(hit), .gc(gc), .addr_match(addr_match), .gc_flag(gc_flag)
  );
endmodule

// File: tb/test_i2c_byte_framer.sv
`timescale 1ns/1ps
module test_i2c_byte_framer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_rise = 0, scl_fall = 0, start_det = 0, stop_det = 0;
  logic [2:0] bit_cnt_cfg = 0;
  logic ack_en = 1, free_data = 0, is_master = 0, dir_tx = 0, gc_ack = 0;
  logic [6:0] own_addr = 7'h5A;
  logic [7:0] tx_data = 0;
  logic tx_take, sda_pull, byte_done, rx_ack, addr_match, gc_flag;
  logic [7:0] rx_byte;
  logic bench_sda = 1'b1;
  logic sda_line;
  assign sda_line = bench_sda & ~sda_pull;

  i2c_byte_framer i_i2c_byte_framer (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_line),
    .bit_cnt_cfg(bit_cnt_cfg), .ack_en(ack_en), .free_data(free_data),
    .own_addr(own_addr), .is_master(is_master), .dir_tx(dir_tx), .gc_ack(gc_ack),
    .tx_data(tx_data), .tx_take(tx_take), .sda_pull(sda_pull), .rx_byte(rx_byte),
    .byte_done(byte_done), .rx_ack(rx_ack), .addr_match(addr_match), .gc_flag(gc_flag)
  );

  int n_cmp = 0, n_bad = 0, done_cnt = 0, take_cnt = 0;
  always @(posedge clk) begin
    if (byte_done) done_cnt <= done_cnt + 1;
    if (tx_take)   take_cnt <= take_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_w(input logic [2:0] c);
    return (c == 0) ? 8 : int'(c);
  endfunction
  function automatic logic [7:0] mask_w(input logic [7:0] v, input int n);
    return (n >= 8) ? v : (v & ((8'd1 << n) - 8'd1));
  endfunction

  task automatic do_start();
    @(negedge clk) start_det = 1; @(negedge clk) start_det = 0; @(negedge clk);
  endtask
  task automatic do_stop();
    @(negedge clk) stop_det = 1; @(negedge clk) stop_det = 0; @(negedge clk);
  endtask

  task automatic bit_slot(input logic b, output logic pulled);
    @(negedge clk) scl_fall = 1; @(negedge clk) scl_fall = 0; @(negedge clk);
    pulled = sda_pull;
    bench_sda = b;
    @(negedge clk) scl_rise = 1; @(negedge clk) scl_rise = 0; @(negedge clk);
  endtask

  task automatic xfer(input int n, input bit ackclk, input logic [7:0] val,
                      input logic back, input logic [7:0] nxt,
                      output logic [7:0] dbits, output logic apull);
    logic p;
    dbits = 0; apull = 0;
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && !ackclk) tx_data = nxt;
      bit_slot(val[n-1-i], p);
      dbits = {dbits[6:0], ~p};
    end
    if (ackclk) begin
      tx_data = nxt;
      bit_slot(back, apull);
    end
    bench_sda = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] db, v, txv;
    logic ap, p;
    int d0, t0, w_cur;
    logic [2:0] nc;
    void'($urandom(32'h1C2B));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 sda_pull", sda_pull, 0);
    chk("R12 byte_done", byte_done, 0);
    chk("R12 rx_byte", rx_byte, 0);
    chk("R12 flags", {rx_ack, addr_match, gc_flag}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 R2 R11: addressed slave write, cfg=5 ignored for the address unit
    bit_cnt_cfg = 3'd5; ack_en = 1;
    t0 = take_cnt;
    do_start();
    chk("R11 tx_take on start", take_cnt, t0 + 1);
    d0 = done_cnt;
    xfer(8, 1, {7'h5A, 1'b0}, 1, 0, db, ap);
    chk("R7 address acked", ap, 1);
    chk("R7 addr_match", addr_match, 1);
    chk("R2 eight-bit address unit", rx_byte, 8'hB4);
    chk("R11 byte_done after ack", done_cnt, d0 + 1);
    // R1 five-bit unit, right-aligned
    xfer(5, 1, 8'h13, 1, 0, db, ap);
    chk("R1 five-bit rx", rx_byte, 8'h13);
    chk("R5 receiver ack", ap, 1);
    // R1 R3 R5 random widths and ack modes
    w_cur = 5;
    for (int k = 0; k < 16; k++) begin
      nc = 3'($urandom_range(0, 7));
      v = 8'($urandom);
      ack_en = 1'($urandom);
      bit_cnt_cfg = nc;
      xfer(w_cur, 1, v, 1, 0, db, ap);
      chk("R1 R3 random rx", rx_byte, mask_w(v, w_cur));
      chk("R5 random ack", ap, ack_en);
      w_cur = exp_w(nc);
    end
    do_stop();

    // R8 foreign address: silent until next start
    ack_en = 1; bit_cnt_cfg = 0;
    do_start();
    xfer(8, 1, {7'h11, 1'b0}, 1, 0, db, ap);
    chk("R8 no ack", ap, 0);
    chk("R8 addr_match low", addr_match, 0);
    xfer(8, 1, 8'h00, 1, 0, db, ap);
    chk("R8 line released on data", db, 8'hFF);
    chk("R8 no data ack", ap, 0);
    do_start();
    xfer(8, 1, {7'h5A, 1'b0}, 1, 0, db, ap);
    chk("R8 new start re-arms", ap, 1);
    do_stop();

    // R9 general call
    do_start();
    xfer(8, 1, 8'h00, 1, 0, db, ap);
    chk("R9 gc acked", ap, 1);
    chk("R9 gc_flag", gc_flag, 1);
    gc_ack = 0;
    xfer(8, 1, 8'h06, 1, 0, db, ap);
    chk("R9 second unit follows gc_ack=0", ap, 0);
    chk("R9 second unit data", rx_byte, 8'h06);
    xfer(8, 1, 8'h21, 1, 0, db, ap);
    chk("R9 third unit follows ack_en", ap, 1);
    chk("R9 flag held", gc_flag, 1);
    do_stop();
    chk("R9 stop clears flag", gc_flag, 0);
    do_start();
    xfer(8, 1, 8'h00, 1, 0, db, ap);
    ack_en = 0; gc_ack = 1;
    xfer(8, 1, 8'h07, 1, 0, db, ap);
    chk("R9 gc_ack=1 overrides ack_en=0", ap, 1);
    do_stop();
    gc_ack = 0;

    // R10 free data
    free_data = 1; ack_en = 1;
    do_start();
    xfer(8, 1, 8'h33, 1, 0, db, ap);
    chk("R10 first unit is data", rx_byte, 8'h33);
    chk("R10 acked by ack_en", ap, 1);
    chk("R10 no address flags", {addr_match, gc_flag}, 0);
    do_start();
    xfer(8, 1, 8'h00, 1, 0, db, ap);
    chk("R10 zero is not general call", gc_flag, 0);
    do_stop();
    free_data = 0;

    // R6 slave without ack mode still counts the ack clock
    ack_en = 1;
    do_start();
    xfer(8, 1, {7'h5A, 1'b0}, 1, 0, db, ap);
    ack_en = 0;
    d0 = done_cnt;
    xfer(8, 0, 8'h9C, 1, 0, db, ap);
    chk("R6 slave waits for ack clock", done_cnt, d0);
    bit_slot(1'b1, p);
    chk("R5 no pull with ack_en=0", p, 0);
    chk("R6 done after slave ack clock", done_cnt, d0 + 1);
    do_stop();

    // R4 slave transmit
    ack_en = 1; dir_tx = 1;
    txv = 8'($urandom);
    do_start();
    xfer(8, 1, {7'h5A, 1'b1}, 1, txv, db, ap);
    chk("R7 read address acked", ap, 1);
    xfer(8, 1, 8'hFF, 0, 8'h3C, db, ap);
    chk("R3 slave tx bits", db, txv);
    chk("R4 tx releases ack slot", ap, 0);
    chk("R4 ack seen", rx_ack, 1);
    xfer(8, 1, 8'hFF, 1, 0, db, ap);
    chk("R3 second tx unit", db, 8'h3C);
    chk("R4 nack seen", rx_ack, 0);
    do_stop();
    dir_tx = 0;

    // R4 R6 R1 master
    is_master = 1; dir_tx = 1; ack_en = 1; bit_cnt_cfg = 3;
    tx_data = 8'hA6;
    do_start();
    txv = 8'($urandom);
    xfer(8, 1, 8'hFF, 0, txv, db, ap);
    chk("R2 master address 8 bits", db, 8'hA6);
    chk("R4 master releases ack", ap, 0);
    chk("R4 master sees ack", rx_ack, 1);
    ack_en = 0; bit_cnt_cfg = 0;
    d0 = done_cnt;
    xfer(3, 0, 8'hFF, 1, 0, db, ap);
    chk("R1 three-bit tx top bits", db, {5'b0, txv[7:5]});
    chk("R6 master no ack clock", done_cnt, d0 + 1);
    dir_tx = 0; ack_en = 1;
    xfer(8, 1, 8'h5C, 1, 0, db, ap);
    chk("R5 master receiver acks", ap, 1);
    chk("R3 master rx data", rx_byte, 8'h5C);
    do_stop();
    is_master = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule